// File: doc/BRIEF.md
# Serial-Loaded Double-Buffered DAC Register Bank

This block is the digital front end of an eight-channel converter. A three-wire serial port (frame sync, serial clock, data) fills a 16-bit shift register. Each complete word is written into one of eight holding registers, and the upper address nibble of the word picks which one. A separate active-low load input moves every holding register into its output latch. The latches drive eight parallel 12-bit code buses toward the converter cores. Holding the load low makes the bank transparent, so each write reaches its channel directly. Pulsing the load instead updates all channels together.

A serial data output repeats the input stream 16 serial clock edges later, so several devices can share one data line in a chain. All serial and load inputs are asynchronous to the system clock. They pass through two-flop synchronizers, and edges are detected in the system clock domain. The serial clock must run at no more than a quarter of the system clock rate. A resolution parameter of 12, 10 or 8 bits keeps codes left-aligned in the 12-bit field and zeroes the unused low bits.

Top module: `dac_serial_bank`

## Requirements
- R1: After the power-on reset, every code output is 0 and the serial data output is 0.
- R2: A falling edge of frame sync opens a frame. Data is sampled on each falling serial clock edge, most significant bit first. After the 16th bit, the word is complete, with bits 15:12 as the address and bits 11:0 as the code.
- R3: Address values 0 to 7 write holding register 0 to 7. Address values 8 to 15 change no register.
- R4: While the load input is high, no code output changes, even when words are written. When load goes low, every channel shows its latest holding value.
- R5: While the load input is low, a written code appears on its channel at the latest 8 system clocks after frame sync rises at the end of the frame.
- R6: If frame sync rises before 16 bits have arrived, the partial frame is dropped and no register is written.
- R7: After each falling serial clock edge, the serial data output carries the bit sampled 16 falling edges earlier. It carries 0 while fewer than 16 bits have been seen since reset.
- R8: With resolution N (12, 10 or 8), a stored code has its low 12-N bits forced to 0. For N=8, a written 0xFFF reads as 0xFF0.
- R9: A write to one channel leaves the other seven channels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| fsync_i | input | 1 | Frame sync, falling edge opens a frame |
| sclk_i | input | 1 | Serial clock, data sampled on falling edges |
| sdin_i | input | 1 | Serial data in, MSB first |
| load_n_i | input | 1 | Active-low, level-sensitive latch transfer |
| sdout_o | output | 1 | Daisy-chain output, input delayed by 16 edges |
| code_o | output | 96 | Eight 12-bit codes, channel k at bits 12k+11:12k |

## Verification
The bench builds two copies of the block side by side on the same stimulus. One is built at full 12-bit resolution and the other at 8-bit resolution. The full-width copy shows that every code bit passes through unchanged, across random addresses and data. The 8-bit copy brings the left-aligned masking of the low nibble into reach, including the all-ones code.

// File: rtl/dac_pkg.sv
package dac_pkg;
  localparam int CODE_W  = 12;
  localparam int ADDR_W  = 4;
  localparam int FRAME_W = CODE_W + ADDR_W;

  // Clear the low bits that a reduced-resolution converter does not use.
  function automatic logic [CODE_W-1:0] clip_code(input logic [CODE_W-1:0] c, input int res);
    logic [CODE_W-1:0] keep;
    keep = '1;
    for (int b = 0; b < CODE_W; b++)
      if (b < CODE_W - res) keep[b] = 1'b0;
    return c & keep;
  endfunction

  function automatic logic [ADDR_W-1:0] word_addr(input logic [FRAME_W-1:0] w);
    return w[FRAME_W-1 -: ADDR_W];
  endfunction

  function automatic logic [CODE_W-1:0] word_code(input logic [FRAME_W-1:0] w);
    return w[CODE_W-1:0];
  endfunction
endpackage

// File: rtl/dac_sync.sv
module dac_sync #(
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= RST_VAL[g];
        s2 <= RST_VAL[g];
      end else begin
        s1 <= async_i[g];
        s2 <= s1;
      end
    end
    assign sync_o[g] = s2;
  end
endmodule

// File: rtl/dac_serial_rx.sv
module dac_serial_rx
  import dac_pkg::*;
#(
  parameter int WORD_W = FRAME_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fs_s,
  input  logic              sck_s,
  input  logic              din_s,
  output logic              word_done,
  output logic [WORD_W-1:0] word,
  output logic              dout
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic              fs_q, sck_q, active;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] shreg, dly;
  logic              fs_fall, fs_rise, sck_fall, last_bit;

  assign fs_fall  = fs_q & ~fs_s;
  assign fs_rise  = ~fs_q & fs_s;
  assign sck_fall = sck_q & ~sck_s;
  assign last_bit = active && sck_fall && (cnt == LAST) && !fs_rise && !fs_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q      <= 1'b1;
      sck_q     <= 1'b1;
      active    <= 1'b0;
      cnt       <= '0;
      shreg     <= '0;
      word_done <= 1'b0;
    end else begin
      fs_q      <= fs_s;
      sck_q     <= sck_s;
      word_done <= last_bit;
      if (fs_fall) begin
        active <= 1'b1;
        cnt    <= '0;
      end else if (fs_rise) begin
        active <= 1'b0;
      end else if (active && sck_fall) begin
        shreg <= {shreg[WORD_W-2:0], din_s};
        cnt   <= cnt + 1'b1;
        if (cnt == LAST) active <= 1'b0;
      end
    end
  end

  // Daisy-chain delay line: runs on every falling serial edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly  <= '0;
      dout <= 1'b0;
    end else if (sck_fall) begin
      dly  <= {dly[WORD_W-2:0], din_s};
      dout <= dly[WORD_W-1];
    end
  end

  assign word = shreg;

  // R6
  idle_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> $stable(shreg));
  // R2
  frame_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |-> !active);
  // R7
  dout_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_fall |=> $stable(dout));
endmodule

// File: rtl/dac_reg_bank.sv
module dac_reg_bank
  import dac_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int RES_BITS = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     word_done,
  input  logic [FRAME_W-1:0]       word,
  input  logic                     load_act,
  output logic [NUM_CH*CODE_W-1:0] codes
);
  logic [NUM_CH-1:0] hold_we;
  logic [CODE_W-1:0] hold  [NUM_CH];
  logic [CODE_W-1:0] latch [NUM_CH];
  logic [ADDR_W-1:0] addr;

  assign addr = word_addr(word);

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    assign hold_we[k] = word_done && (int'(addr) == k);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hold[k]  <= '0;
        latch[k] <= '0;
      end else begin
        if (hold_we[k]) hold[k] <= clip_code(word_code(word), RES_BITS);
        if (load_act)   latch[k] <= hold[k];
      end
    end
    assign codes[k*CODE_W +: CODE_W] = latch[k];

    // R4
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load_act |=> $stable(latch[k]));
    // R8
    res_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clip_code(latch[k], RES_BITS) == latch[k]);
  end

  // R3
  one_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hold_we));
  // R3
  bad_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && int'(addr) >= NUM_CH) |-> hold_we == '0);
endmodule

// File: rtl/dac_serial_bank.sv
module dac_serial_bank
  import dac_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int RES_BITS = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fsync_i,
  input  logic                     sclk_i,
  input  logic                     sdin_i,
  input  logic                     load_n_i,
  output logic                     sdout_o,
  output logic [NUM_CH*CODE_W-1:0] code_o
);
  logic [3:0]         raw, syn;
  logic               word_done;
  logic [FRAME_W-1:0] word;

  assign raw = {load_n_i, fsync_i, sclk_i, sdin_i};

  dac_sync #(.W(4), .RST_VAL(4'b1110)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(raw), .sync_o(syn)
  );

  dac_serial_rx #(.WORD_W(FRAME_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .fs_s(syn[2]), .sck_s(syn[1]), .din_s(syn[0]),
    .word_done(word_done), .word(word), .dout(sdout_o)
  );

  dac_reg_bank #(.NUM_CH(NUM_CH), .RES_BITS(RES_BITS)) u_bank (
    .clk(clk), .rst_n(rst_n), .word_done(word_done), .word(word),
    .load_act(~syn[3]), .codes(code_o)
  );
endmodule

// File: tb/dac_serial_bank_test.sv
module dac_serial_bank_test;
  logic clk = 0, rst_n = 0;
  logic fsync = 1, sclk = 1, sdin = 0, load_n = 1;
  logic sdout, sdout8;
  logic [95:0] code, code8;

  int total = 0, fails = 0;
  bit finished = 0;
  logic [11:0] m_hold [8];
  logic [11:0] m_out  [8];
  bit bitq [$];

  always #10 clk = ~clk;

  dac_serial_bank #(.NUM_CH(8), .RES_BITS(12)) uut (
    .clk(clk), .rst_n(rst_n), .fsync_i(fsync), .sclk_i(sclk), .sdin_i(sdin),
    .load_n_i(load_n), .sdout_o(sdout), .code_o(code));
  dac_serial_bank #(.NUM_CH(8), .RES_BITS(8)) uut8 (
    .clk(clk), .rst_n(rst_n), .fsync_i(fsync), .sclk_i(sclk), .sdin_i(sdin),
    .load_n_i(load_n), .sdout_o(sdout8), .code_o(code8));

  function automatic logic [11:0] low_trim(logic [11:0] v, int res);
    return (v >> (12 - res)) << (12 - res);
  endfunction

  task automatic wclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor side of the daisy-chain scoreboard.
  task automatic mon_dout();
    bit e;
    e = bitq.pop_front();
    check("R7 sdout", {31'b0, sdout}, {31'b0, e});
  endtask

  task automatic check_all(string req);
    for (int c = 0; c < 8; c++) begin
      check(req, {20'b0, code[c*12 +: 12]}, {20'b0, m_out[c]});
      check({req, " R8 res8"}, {20'b0, code8[c*12 +: 12]}, {20'b0, low_trim(m_out[c], 8)});
    end
  endtask

  // Driver: shifts nbits of a word and pushes expectations.
  task automatic send(logic [3:0] a, logic [11:0] d, int nbits);
    logic [15:0] w;
    w = {a, d};
    fsync = 0; wclk(4);
    for (int i = 0; i < nbits; i++) begin
      sdin = w[15 - i];
      bitq.push_back(sdin);
      wclk(4);
      sclk = 0; wclk(4);
      mon_dout();
      sclk = 1;
    end
    wclk(2);
    fsync = 1; wclk(8);
    if (nbits == 16 && a < 8) m_hold[a[2:0]] = d;
    if (!load_n) for (int c = 0; c < 8; c++) m_out[c] = m_hold[c];
  endtask

  task automatic finish_sim();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin
    for (int c = 0; c < 8; c++) begin m_hold[c] = 0; m_out[c] = 0; end
    for (int i = 0; i < 16; i++) bitq.push_back(1'b0);
    wclk(3); rst_n = 1; wclk(3);
    // R1 reset state
    check_all("R1 reset");
    check("R1 sdout", {31'b0, sdout}, 0);

    // R5 transparent mode, R2 framing, R9 isolation
    load_n = 0; wclk(6);
    send(4'd3, 12'hABC, 16);
    check_all("R5 R2 R9 single write");

    for (int n = 0; n < 8; n++) begin
      send(4'($urandom_range(0, 7)), 12'($urandom), 16);
      check_all("R2 R5 random");
    end

    // R3 ignored addresses
    send(4'd9, 12'h123, 16);
    check_all("R3 addr 9");
    send(4'd15, 12'hFFF, 16);
    check_all("R3 addr 15");

    // R6 partial frame
    send(4'd0, 12'h5A5, 10);
    check_all("R6 partial");
    send(4'd1, 12'h777, 15);
    check_all("R6 partial 15");

    // R4 held outputs while load high, then group update
    load_n = 1; wclk(6);
    send(4'd1, 12'h111, 16);
    send(4'd2, 12'h2F2, 16);
    check_all("R4 load high");
    send(4'd6, 12'h606, 16);
    check_all("R4 load high");
    load_n = 0; wclk(6);
    for (int c = 0; c < 8; c++) m_out[c] = m_hold[c];
    check_all("R4 load low");

    // R8 full-scale code on 8-bit copy
    send(4'd7, 12'hFFF, 16);
    check_all("R8 full scale");
    check("R8 res8 ch7", {20'b0, code8[84 +: 12]}, 32'hFF0);
    send(4'd0, 12'h00F, 16);
    check("R8 res8 ch0", {20'b0, code8[0 +: 12]}, 32'h000);
    check_all("R9 after ch0");

    finish_sim();
  end
endmodule